// File: doc/BRIEF.md
# Four-Tap FIR Filter Built from Reversible Gates

This block is a four-tap direct-form FIR filter. Each cycle in which the sample strobe is high, it takes one signed sample and registers y(n) = c0·x(n) + c1·x(n−1) + c2·x(n−2) + c3·x(n−3). The four signed coefficients live in registers that a small write port loads one tap at a time.

The datapath is built only from three combinational reversible-gate primitives. A two-line copy gate (out0 = a, out1 = a XOR b) does all signal duplication. A three-line AND cell (a, a XOR b, (a AND b) XOR c) forms the partial products. A four-line adder cell (a, b, a^b^c, ((a^b)&c)^((a&b)^d)) acts as a full adder when d is tied to 0. No datapath wire drives more than one gate input. Every gate output that is not used goes to a named garbage net, and every extra gate input is tied to a constant.

Products are full-width two's complement values. They are sign-extended by two bits before the adder tree, so the sum of four extreme products cannot overflow.

Top module: `fir4_rev`

## Requirements
- R1: A synchronous active-high `rst` clears the sample history, all four coefficients, `y_out` and `y_vld` to zero.
- R2: When `smp_vld` is high at a rising edge, `y_out` shows the 18-bit two's complement value of Σ c_k·x(n−k) after that edge. x(n) is `smp_in` and x(n−1..n−3) are earlier accepted samples. All operands are signed 8-bit.
- R3: The output is exact at the extremes of the operand range. Four products of −128·−128 give +65536, and four products of −128·127 give −65024.
- R4: The history shifts only on edges where `smp_vld` is high. Idle cycles between samples do not change which samples the taps hold.
- R5: `y_vld` equals `smp_vld` delayed by exactly one clock cycle.
- R6: While no sample is accepted, `y_out` holds its last value.
- R7: `cw_en` high at an edge writes `cw_val` into coefficient c_k, where k is the value of `cw_sel` (0 weights the newest sample, 3 the oldest). A write in the same cycle as a sample strobe is not used for that sample. It applies from the next accepted sample on.
- R8: A coefficient write with no sample strobe changes neither `y_out`, `y_vld` nor the sample history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Sample strobe |
| smp_in | input | 8 | Signed input sample |
| cw_en | input | 1 | Coefficient write enable |
| cw_sel | input | 2 | Coefficient tap index |
| cw_val | input | 8 | Signed coefficient value |
| y_vld | output | 1 | Output valid, one cycle after the strobe |
| y_out | output | 18 | Signed filter output |

## Verification
A coefficient write and a sample strobe can fall in the same cycle. The write must then stay invisible to that sample and take effect on the next one. The bench provokes this with a step task that raises both strobes together, during directed sequences and during a random phase. Its arithmetic model applies the new coefficient only after it has computed the expected output for that sample. The bench also sweeps every coefficient value against a set of samples and every sample value through each tap, so that every partial-product row and every sign-extension path of the gate-level multipliers is exercised.

// File: rtl/fir4_rev_pkg.sv
package fir4_rev_pkg;
   localparam int TAPS = 4;
   localparam int SELW = $clog2(TAPS);
endpackage

// File: rtl/rv_gates.sv
module rv_feynman (
   input  logic a,
   input  logic b,
   output logic p,
   output logic q
);
   assign p = a;
   assign q = a ^ b;
endmodule

module rv_peres (
   input  logic a,
   input  logic b,
   input  logic c,
   output logic p,
   output logic q,
   output logic r
);
   assign p = a;
   assign q = a ^ b;
   assign r = (a & b) ^ c;
endmodule

module rv_hng (
   input  logic a,
   input  logic b,
   input  logic c,
   input  logic d,
   output logic p,
   output logic q,
   output logic r,
   output logic s
);
   assign p = a;
   assign q = b;
   assign r = a ^ b ^ c;
   assign s = ((a ^ b) & c) ^ ((a & b) ^ d);
endmodule

// File: rtl/rv_fanout.sv
module rv_fanout #(
   parameter int N = 2
) (
   input  logic         src,
   output logic [N-1:0] dup
);
   if (N < 1) begin : g_bad
      $error("rv_fanout: N must be at least 1");
   end
   if (N == 1) begin : g_pass
      assign dup[0] = src;
   end else begin : g_chain
      logic [N-1:0] link;
      assign link[0] = src;
      for (genvar i = 0; i < N-1; i++) begin : g_cp
         rv_feynman u_fg (.a(link[i]), .b(1'b0), .p(link[i+1]), .q(dup[i]));
      end
      assign dup[N-1] = link[N-1];
   end
endmodule

// File: rtl/rv_sext.sv
module rv_sext #(
   parameter int IW = 8,
   parameter int OW = 16
) (
   input  logic [IW-1:0] din,
   output logic [OW-1:0] dout
);
   localparam int NCP = OW - IW + 1;
   if (IW < 2 || OW < IW) begin : g_bad
      $error("rv_sext: need IW >= 2 and OW >= IW");
   end
   assign dout[IW-2:0] = din[IW-2:0];
   rv_fanout #(.N(NCP)) u_sgn (.src(din[IW-1]), .dup(dout[OW-1:IW-1]));
endmodule

// File: rtl/rv_ripple_add.sv
module rv_ripple_add #(
   parameter int W = 18
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] sum
);
   logic [W-1:0] cy;
   logic [W-1:0] unused_pa, unused_pb;
   logic         unused_cout;
   assign cy[0] = 1'b0;
   for (genvar i = 0; i < W; i++) begin : g_bit
      if (i < W-1) begin : g_mid
         rv_hng u_fa (.a(a[i]), .b(b[i]), .c(cy[i]), .d(1'b0),
                      .p(unused_pa[i]), .q(unused_pb[i]), .r(sum[i]), .s(cy[i+1]));
      end else begin : g_top
         rv_hng u_fa (.a(a[i]), .b(b[i]), .c(cy[i]), .d(1'b0),
                      .p(unused_pa[i]), .q(unused_pb[i]), .r(sum[i]), .s(unused_cout));
      end
   end
endmodule

// File: rtl/rv_mul.sv
module rv_mul #(
   parameter int W = 16
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] prod
);
   logic [W-1:0] rs [W];

   for (genvar k = 0; k < W; k++) begin : g_a
      logic [W-k-1:0] cp;
      rv_fanout #(.N(W-k)) u_cp (.src(a[k]), .dup(cp));
   end
   for (genvar i = 0; i < W; i++) begin : g_b
      logic [W-i-1:0] cp;
      rv_fanout #(.N(W-i)) u_cp (.src(b[i]), .dup(cp));
   end

   for (genvar i = 0; i < W; i++) begin : g_row
      logic [W-i-1:0] pp;
      logic [W-i-1:0] unused_pp_p, unused_pp_q;
      for (genvar c = 0; c < W-i; c++) begin : g_and
         rv_peres u_and (.a(g_a[c].cp[i]), .b(g_b[i].cp[c]), .c(1'b0),
                         .p(unused_pp_p[c]), .q(unused_pp_q[c]), .r(pp[c]));
      end
      if (i == 0) begin : g_first
         assign rs[0] = pp;
      end else begin : g_acc
         logic [W-i-1:0] cy;
         logic [W-i-1:0] unused_fa_p, unused_fa_q;
         logic           unused_cout;
         assign cy[0] = 1'b0;
         assign rs[i][i-1:0] = rs[i-1][i-1:0];
         for (genvar c = 0; c < W-i; c++) begin : g_fa
            if (c < W-i-1) begin : g_mid
               rv_hng u_fa (.a(rs[i-1][i+c]), .b(pp[c]), .c(cy[c]), .d(1'b0),
                            .p(unused_fa_p[c]), .q(unused_fa_q[c]),
                            .r(rs[i][i+c]), .s(cy[c+1]));
            end else begin : g_top
               rv_hng u_fa (.a(rs[i-1][i+c]), .b(pp[c]), .c(cy[c]), .d(1'b0),
                            .p(unused_fa_p[c]), .q(unused_fa_q[c]),
                            .r(rs[i][i+c]), .s(unused_cout));
            end
         end
      end
   end

   assign prod = rs[W-1];
endmodule

// File: rtl/fir4_rev.sv
module fir4_rev
   import fir4_rev_pkg::*;
#(
   parameter int DW = 8,
   parameter int CW = 8
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            smp_vld,
   input  logic [DW-1:0]   smp_in,
   input  logic            cw_en,
   input  logic [SELW-1:0] cw_sel,
   input  logic [CW-1:0]   cw_val,
   output logic            y_vld,
   output logic [DW+CW+SELW-1:0] y_out
);
   localparam int PW = DW + CW;
   localparam int AW = PW + SELW;

   if (TAPS != 4) begin : g_bad_taps
      $error("fir4_rev: adder tree is built for four taps");
   end
   if (DW < 2 || CW < 2 || PW > 28) begin : g_bad_width
      $error("fir4_rev: operand widths out of range");
   end

   logic [DW-1:0] hist [1:TAPS-1];
   logic [CW-1:0] coef [TAPS];
   logic [DW-1:0] tapv [TAPS];
   logic [DW-1:0] fwd  [TAPS-1];
   logic [AW-1:0] term [TAPS];
   logic [AW-1:0] s01, s23, y_d;
   logic [AW-1:0] y_q;
   logic          vld_q;

   assign tapv[0] = smp_in;
   for (genvar t = 1; t < TAPS; t++) begin : g_tv
      assign tapv[t] = hist[t];
   end

   for (genvar t = 0; t < TAPS; t++) begin : g_tap
      logic [DW-1:0] mx;
      logic [PW-1:0] xe, ce, pr;
      if (t < TAPS-1) begin : g_split
         for (genvar b = 0; b < DW; b++) begin : g_bit
            logic [1:0] dd;
            rv_fanout #(.N(2)) u_cp (.src(tapv[t][b]), .dup(dd));
            assign fwd[t][b] = dd[1];
            assign mx[b]     = dd[0];
         end
      end else begin : g_last
         assign mx = tapv[t];
      end
      rv_sext #(.IW(DW), .OW(PW)) u_xe (.din(mx), .dout(xe));
      rv_sext #(.IW(CW), .OW(PW)) u_ce (.din(coef[t]), .dout(ce));
      rv_mul  #(.W(PW))           u_mul (.a(xe), .b(ce), .prod(pr));
      rv_sext #(.IW(PW), .OW(AW)) u_te (.din(pr), .dout(term[t]));
   end

   rv_ripple_add #(.W(AW)) u_add01 (.a(term[0]), .b(term[1]), .sum(s01));
   rv_ripple_add #(.W(AW)) u_add23 (.a(term[2]), .b(term[3]), .sum(s23));
   rv_ripple_add #(.W(AW)) u_addall (.a(s01), .b(s23), .sum(y_d));

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int t = 1; t < TAPS; t++) hist[t] <= '0;
         for (int t = 0; t < TAPS; t++) coef[t] <= '0;
         y_q   <= '0;
         vld_q <= 1'b0;
      end else begin
         if (cw_en) coef[cw_sel] <= cw_val;
         if (smp_vld) begin
            for (int t = 1; t < TAPS; t++) hist[t] <= fwd[t-1];
            y_q <= y_d;
         end
         vld_q <= smp_vld;
      end
   end

   assign y_out = y_q;
   assign y_vld = vld_q;

   // Arithmetic model used only by the assertions below
   logic [AW-1:0] ref_y;
   always_comb begin
      int acc;
      acc = 0;
      for (int t = 0; t < TAPS; t++)
         acc += int'($signed(tapv[t])) * int'($signed(coef[t]));
      ref_y = acc[AW-1:0];
   end

   a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (y_out == '0 && !y_vld));
   a_r2_sum: assert property (@(posedge clk) disable iff (rst)
      (!rst && smp_vld) |=> (y_out == $past(ref_y)));
   a_r5_vld_high: assert property (@(posedge clk) disable iff (rst)
      (!rst && smp_vld) |=> y_vld);
   a_r5_vld_low: assert property (@(posedge clk) disable iff (rst)
      !smp_vld |=> !y_vld);
   a_r6_hold: assert property (@(posedge clk) disable iff (rst)
      (!rst && !smp_vld) |=> $stable(y_out));
   a_r8_write_only: assert property (@(posedge clk) disable iff (rst)
      (!rst && cw_en && !smp_vld) |=> ($stable(y_out) && !y_vld));
endmodule

// File: tb/sim_fir4_rev.sv
module sim_fir4_rev;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 18;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       smp_vld = 1'b0;
   logic [7:0] smp_in = '0;
   logic       cw_en = 1'b0;
   logic [1:0] cw_sel = '0;
   logic [7:0] cw_val = '0;
   logic       y_vld;
   logic [AW-1:0] y_out;

   int n_chk = 0;
   int n_fail = 0;
   int hm [4];
   int cm [4];
   int last_y = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fir4_rev u0 (.clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_in(smp_in),
                .cw_en(cw_en), .cw_sel(cw_sel), .cw_val(cw_val),
                .y_vld(y_vld), .y_out(y_out));

   function automatic int ysig();
      return int'($signed(y_out));
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 4; i++) begin hm[i] = 0; cm[i] = 0; end
      last_y = 0;
   endtask

   // one accepted sample, optionally with a coefficient write in the same cycle
   task automatic step(input int x, input bit we, input int idx, input int val, input string tag);
      int e;
      smp_vld = 1'b1; smp_in = 8'(x);
      cw_en = we; cw_sel = 2'(idx); cw_val = 8'(val);
      e = x * cm[0] + hm[1] * cm[1] + hm[2] * cm[2] + hm[3] * cm[3];
      @(negedge clk);
      smp_vld = 1'b0; cw_en = 1'b0;
      chk(y_vld == 1'b1, {tag, " R5 valid"}, int'(y_vld), 1);
      chk(y_out == e[AW-1:0], {tag, " R2 value"}, ysig(), e);
      hm[3] = hm[2]; hm[2] = hm[1]; hm[1] = x;
      if (we) cm[idx] = val;
      last_y = e;
   endtask

   task automatic push(input int x, input string tag);
      step(x, 1'b0, 0, 0, tag);
   endtask

   task automatic wr(input int idx, input int val);
      cw_en = 1'b1; cw_sel = 2'(idx); cw_val = 8'(val);
      @(negedge clk);
      cw_en = 1'b0;
      chk(!y_vld && y_out == last_y[AW-1:0], "R8 write leaves output", ysig(), last_y);
      cm[idx] = val;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         chk(y_vld == 1'b0, "R5 no strobe gives no valid", int'(y_vld), 0);
         chk(y_out == last_y[AW-1:0], "R6 output holds", ysig(), last_y);
      end
   endtask

   task automatic set_coefs(input int a, input int b, input int c, input int d);
      wr(0, a); wr(1, b); wr(2, c); wr(3, d);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst = 1'b0;
      chk(y_out == '0 && y_vld == 1'b0, "R1 reset state", ysig(), 0);

      // R1: coefficients are zero after reset
      push(9, "R1 zero coefs");

      // impulse and step responses
      set_coefs(3, -5, 7, -128);
      push(0, "flush"); push(0, "flush"); push(0, "flush");
      push(1, "impulse");
      for (int i = 0; i < 4; i++) push(0, "impulse tail");
      for (int i = 0; i < 5; i++) push(1, "step");

      // R3 extremes
      set_coefs(-128, -128, -128, -128);
      for (int i = 0; i < 4; i++) push(-128, "R3 max positive");
      chk(last_y == 65536, "R3 max positive model", last_y, 65536);
      for (int i = 0; i < 4; i++) push(127, "R3 max negative");
      set_coefs(127, 127, 127, 127);
      for (int i = 0; i < 4; i++) push(-128, "R3 neg mix");
      for (int i = 0; i < 4; i++) push(127, "R3 max product");

      // R4 and R6: idle cycles do not shift the history
      set_coefs(1, 2, 3, 4);
      push(0, "R4 flush"); push(0, "R4 flush"); push(0, "R4 flush");
      push(1, "R4 seed");
      idle(3);
      push(0, "R4 after idle");
      idle(2);
      push(0, "R4 second shift");

      // R7 write together with a sample: old coefficient for this sample
      set_coefs(1, 0, 0, 0);
      step(5, 1'b1, 0, 10, "R7 same cycle old coef");
      push(5, "R7 next sample new coef");
      step(-3, 1'b1, 3, -7, "R7 oldest tap same cycle");
      for (int i = 0; i < 3; i++) push(0, "R7 oldest tap applied");

      // every sample value through each tap alone
      for (int t = 0; t < 4; t++) begin
         set_coefs(t == 0 ? -77 : 0, t == 1 ? 91 : 0, t == 2 ? -128 : 0, t == 3 ? 127 : 0);
         for (int x = -128; x < 128; x++) push(x, "R2 tap sweep");
      end

      // every coefficient value against a spread of samples
      set_coefs(0, 0, 0, 0);
      for (int c = -128; c < 128; c++) begin
         wr(0, c);
         for (int x = -128; x < 128; x += 17) push(x, "R2 coef sweep");
         push(127, "R2 coef sweep top");
      end

      // random mix, with coefficient writes alone and alongside samples
      for (int i = 0; i < 3000; i++) begin
         int r = int'($urandom_range(0, 9));
         int x = int'($urandom_range(0, 255)) - 128;
         int v = int'($urandom_range(0, 255)) - 128;
         int k = int'($urandom_range(0, 3));
         if (r < 2) step(x, 1'b1, k, v, "R7 random joint");
         else if (r == 2) wr(k, v);
         else if (r == 3) idle(1);
         else push(x, "R2 random");
      end

      // R1 mid-run reset clears history and coefficients
      rst = 1'b1;
      @(negedge clk); @(negedge clk);
      rst = 1'b0;
      model_reset();
      chk(y_out == '0 && y_vld == 1'b0, "R1 mid-run reset", ysig(), 0);
      push(9, "R1 coefs cleared");
      set_coefs(1, 1, 1, 1);
      push(11, "R1 history cleared");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule